// File: doc/BRIEF.md
# ADC Bring-Up Command Sequencer

This block drives the serial control port of a delta-sigma converter straight after reset. It plays a fixed command script over a mode-0 SPI link. The script stops any running conversion readout and programs the output rate, gain and filter. It parks the input multiplexer on the internal resistor short and resynchronises the converter. After that it starts readout, waits for the first data-ready low, runs an offset calibration, and restarts readout.

The block then lets a programmable number of data-ready pulses pass while the calibrated zero is being recorded. After those pulses it stops readout again, points the multiplexer at the external input pair and issues the final start-readout command. A sticky done output then tells the sample readout path that it owns the converter. Single-byte commands and three-byte register writes share one shifter. Every frame keeps chip select low from first bit to last, and each frame is separated from the next by a guaranteed idle gap.

Top module: `adc_boot_seq`

## Requirements
- R1: While reset is asserted, chip select is high, the serial clock is low and done is low.
- R2: Frames use SPI mode 0 with the most significant bit first. The serial clock idles low, data is stable while the clock is high, and chip select stays low across every clock pulse of a frame. A frame is exactly 8 or 24 bits.
- R3: The first frame after reset is the single byte 0x11. The first eight frames are 0x11, the rate write, the gain write, the filter write, the short-mux write, 0x11, 0x04 and 0x10, in that order.
- R4: Each register write is one 24-bit frame. Its first byte is the write opcode with the register address in the low bits, its second byte is 0x00 (one register) and its third byte is the value. The defaults are 0x410042 for rate, 0x42000E for gain, 0x410046 for filter, 0x42002E for the short mux and 0x42000E for the external mux.
- R5: Chip select stays high for at least GAP_MCLK × MCLK_DIV clock cycles between two frames, with GAP_MCLK of at least 24.
- R6: After the first 0x10, no frame starts until data-ready has fallen once. Then 0x11, 0x60 and 0x10 follow.
- R7: After the calibration 0x10, no frame starts until SETTLE_PULSES falling edges of data-ready have been seen. Then 0x11, the external-mux write and 0x10 follow.
- R8: Done rises only after the final 0x10 frame has completed, and it stays high until reset.
- R9: Once done is high, data-ready edges start no frame. Chip select stays high.
- R10: Data-ready falling edges that arrive before a wait step is reached are not counted toward that wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the converter |
| done | output | 1 | Bring-up finished, readout path may take over |

## Verification
On every cycle the assertions enforce the SPI framing rules: chip select low under every clock pulse and data held while the clock is high. They also enforce the minimum idle gap between frames, a quiet bus during data-ready waits and after done, a stepping script index that only moves forward by one, and a sticky done. The content and order of the fourteen frames can only be shown by the bench scenarios that decode the bus. The same holds for the fact that waits release only on the right number of data-ready edges, that early or late edges are ignored, and that the script restarts cleanly after a reset.

// File: rtl/adc_boot_pkg.sv
package adc_boot_pkg;
   localparam int NSTEPS = 16;
   localparam int IDXW   = $clog2(NSTEPS);

   localparam logic [7:0] CMD_HALT_RD  = 8'h11;
   localparam logic [7:0] CMD_RESYNC   = 8'h04;
   localparam logic [7:0] CMD_RUN_RD   = 8'h10;
   localparam logic [7:0] CMD_ZERO_CAL = 8'h60;

   typedef enum logic [1:0] {
      K_CMD1,
      K_CMD3,
      K_WAIT1,
      K_WAITN
   } step_kind_e;

   typedef struct packed {
      step_kind_e  kind;
      logic [23:0] word;
   } step_t;

   typedef enum logic [2:0] {
      S_GAP,
      S_ISSUE,
      S_SHIFT,
      S_WAIT,
      S_DONE
   } seq_state_e;
endpackage

// File: rtl/adc_boot_script.sv
module adc_boot_script
   import adc_boot_pkg::*;
#(
   parameter logic [23:0] W_RATE      = 24'h410042,
   parameter logic [23:0] W_GAIN      = 24'h42000E,
   parameter logic [23:0] W_FILT      = 24'h410046,
   parameter logic [23:0] W_MUX_SHORT = 24'h42002E,
   parameter logic [23:0] W_MUX_EXT   = 24'h42000E
) (
   input  logic [IDXW-1:0] idx,
   output step_t           ent,
   output logic            last
);
   // every write frame must be opcode 010xxxxx, count byte 0x00
   localparam logic [4:0][23:0] WRITES = {W_MUX_EXT, W_MUX_SHORT, W_FILT, W_GAIN, W_RATE};
   for (genvar g = 0; g < 5; g++) begin : g_chk
      if (WRITES[g][23:21] != 3'b010 || WRITES[g][15:8] != 8'h00) begin : g_bad
         $error("register write frame %0d is malformed", g);
      end
   end

   always_comb begin
      ent = '{kind: K_CMD1, word: {16'h0, CMD_HALT_RD}};
      case (idx)
         4'd0:    ent = '{K_CMD1,  {16'h0, CMD_HALT_RD}};
         4'd1:    ent = '{K_CMD3,  W_RATE};
         4'd2:    ent = '{K_CMD3,  W_GAIN};
         4'd3:    ent = '{K_CMD3,  W_FILT};
         4'd4:    ent = '{K_CMD3,  W_MUX_SHORT};
         4'd5:    ent = '{K_CMD1,  {16'h0, CMD_HALT_RD}};
         4'd6:    ent = '{K_CMD1,  {16'h0, CMD_RESYNC}};
         4'd7:    ent = '{K_CMD1,  {16'h0, CMD_RUN_RD}};
         4'd8:    ent = '{K_WAIT1, 24'h0};
         4'd9:    ent = '{K_CMD1,  {16'h0, CMD_HALT_RD}};
         4'd10:   ent = '{K_CMD1,  {16'h0, CMD_ZERO_CAL}};
         4'd11:   ent = '{K_CMD1,  {16'h0, CMD_RUN_RD}};
         4'd12:   ent = '{K_WAITN, 24'h0};
         4'd13:   ent = '{K_CMD1,  {16'h0, CMD_HALT_RD}};
         4'd14:   ent = '{K_CMD3,  W_MUX_EXT};
         default: ent = '{K_CMD1,  {16'h0, CMD_RUN_RD}};
      endcase
   end

   assign last = (idx == IDXW'(NSTEPS - 1));
endmodule

// File: rtl/adc_boot_spi.sv
module adc_boot_spi #(
   parameter int SCLK_HALF = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        wide,
   input  logic [23:0] frame,
   output logic        sclk,
   output logic        cs_n,
   output logic        mosi,
   output logic        fin
);
   localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

   if (SCLK_HALF < 1) begin : g_bad_half
      $error("SCLK_HALF must be at least 1");
   end

   logic [23:0]   sh;
   logic [4:0]    bits;
   logic [DW-1:0] div;
   logic          busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0; bits <= '0; div <= '0;
         busy <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0; fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               cs_n <= 1'b0;
               div  <= '0;
               sh   <= wide ? frame : {frame[7:0], 16'h0};
               bits <= wide ? 5'd24 : 5'd8;
            end
         end else if (div == DW'(SCLK_HALF - 1)) begin
            div <= '0;
            if (!sclk) begin
               sclk <= 1'b1;
            end else begin
               sclk <= 1'b0;
               sh   <= sh << 1;
               bits <= bits - 5'd1;
               if (bits == 5'd1) begin
                  busy <= 1'b0;
                  cs_n <= 1'b1;
                  fin  <= 1'b1;
               end
            end
         end else begin
            div <= div + DW'(1);
         end
      end
   end

   assign mosi = sh[23];

   // R2: chip select low under every clock pulse
   p_cs_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);
   // R2: data held while the clock is high
   p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/adc_boot_seq.sv
module adc_boot_seq
   import adc_boot_pkg::*;
#(
   parameter int          SCLK_HALF     = 2,
   parameter int          MCLK_DIV      = 2,
   parameter int          GAP_MCLK      = 24,
   parameter int          SETTLE_PULSES = 4,
   parameter int          SYNC_STAGES   = 2,
   parameter logic [23:0] W_RATE        = 24'h410042,
   parameter logic [23:0] W_GAIN        = 24'h42000E,
   parameter logic [23:0] W_FILT        = 24'h410046,
   parameter logic [23:0] W_MUX_SHORT   = 24'h42002E,
   parameter logic [23:0] W_MUX_EXT     = 24'h42000E
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drdy_n,
   output logic sclk,
   output logic cs_n,
   output logic mosi,
   output logic done
);
   localparam int GAP_CLKS = GAP_MCLK * MCLK_DIV;
   localparam int GW       = $clog2(GAP_CLKS + 1);
   localparam int SW       = $clog2(SETTLE_PULSES + 1);

   if (GAP_MCLK < 24) begin : g_bad_gap
      $error("GAP_MCLK must be at least 24");
   end
   if (MCLK_DIV < 1 || SETTLE_PULSES < 1 || SYNC_STAGES < 0) begin : g_bad_par
      $error("MCLK_DIV and SETTLE_PULSES must be positive, SYNC_STAGES non-negative");
   end

   // data-ready synchroniser, depth chosen by parameter
   logic drdy_s, drdy_q, drdy_fall;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign drdy_s = drdy_n;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '1;
         else        sr <= (sr << 1) | SYNC_STAGES'(drdy_n);
      end
      assign drdy_s = sr[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drdy_q <= 1'b1;
      else        drdy_q <= drdy_s;
   end
   assign drdy_fall = drdy_q & ~drdy_s;

   seq_state_e      state;
   logic [IDXW-1:0] step;
   logic [GW-1:0]   gap;
   logic [SW-1:0]   pulses, need_m1;
   step_t           ent;
   logic            last, is_wait, spi_start, spi_fin;

   adc_boot_script #(
      .W_RATE(W_RATE), .W_GAIN(W_GAIN), .W_FILT(W_FILT),
      .W_MUX_SHORT(W_MUX_SHORT), .W_MUX_EXT(W_MUX_EXT)
   ) u_script (
      .idx (step),
      .ent (ent),
      .last(last)
   );

   assign is_wait   = (ent.kind == K_WAIT1) || (ent.kind == K_WAITN);
   assign need_m1   = (ent.kind == K_WAIT1) ? '0 : SW'(SETTLE_PULSES - 1);
   assign spi_start = (state == S_ISSUE) && !is_wait;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_GAP;
         step   <= '0;
         gap    <= GW'(GAP_CLKS - 1);
         pulses <= '0;
      end else begin
         case (state)
            S_GAP: begin
               if (gap == '0) state <= S_ISSUE;
               else           gap   <= gap - GW'(1);
            end
            S_ISSUE: begin
               pulses <= '0;
               state  <= is_wait ? S_WAIT : S_SHIFT;
            end
            S_SHIFT: begin
               if (spi_fin) begin
                  if (last) begin
                     state <= S_DONE;
                  end else begin
                     step  <= step + IDXW'(1);
                     gap   <= GW'(GAP_CLKS - 1);
                     state <= S_GAP;
                  end
               end
            end
            S_WAIT: begin
               if (drdy_fall) begin
                  if (pulses == need_m1) begin
                     step  <= step + IDXW'(1);
                     gap   <= GW'(GAP_CLKS - 1);
                     state <= S_GAP;
                  end else begin
                     pulses <= pulses + SW'(1);
                  end
               end
            end
            default: state <= S_DONE;
         endcase
      end
   end

   assign done = (state == S_DONE);

   adc_boot_spi #(.SCLK_HALF(SCLK_HALF)) u_spi (
      .clk  (clk),
      .rst_n(rst_n),
      .start(spi_start),
      .wide (ent.kind == K_CMD3),
      .frame(ent.word),
      .sclk (sclk),
      .cs_n (cs_n),
      .mosi (mosi),
      .fin  (spi_fin)
   );

   // idle-gap monitor counter (saturating)
   logic [GW:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      hi_cnt <= '0;
      else if (!cs_n)                  hi_cnt <= '0;
      else if (hi_cnt < (GW+1)'(GAP_CLKS)) hi_cnt <= hi_cnt + 1'b1;
   end

   p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> ($past(hi_cnt) >= (GW+1)'(GAP_CLKS)));
   p_wait_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT) |-> cs_n);
   p_step_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step != $past(step)) |-> (step == $past(step) + IDXW'(1)));
   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !sclk));
endmodule

// File: tb/adc_boot_seq_bench.sv
module adc_boot_seq_bench;
   localparam int SETTLE = 4;
   localparam int GAPC   = 24 * 2;
   localparam int NFR    = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic drdy_n = 1'b1;
   logic sclk, cs_n, mosi, done;

   always #10 clk = ~clk;

   adc_boot_seq #(.SCLK_HALF(2), .MCLK_DIV(2), .GAP_MCLK(24), .SETTLE_PULSES(SETTLE))
   u_adc_boot_seq (
      .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n),
      .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .done(done)
   );

   // expected frames: {bit length, right-aligned data}
   localparam logic [31:0] EXP [NFR] = '{
      {8'd8, 24'h000011}, {8'd24, 24'h410042}, {8'd24, 24'h42000E},
      {8'd24, 24'h410046}, {8'd24, 24'h42002E}, {8'd8, 24'h000011},
      {8'd8, 24'h000004}, {8'd8, 24'h000010}, {8'd8, 24'h000011},
      {8'd8, 24'h000060}, {8'd8, 24'h000010}, {8'd8, 24'h000011},
      {8'd24, 24'h42000E}, {8'd8, 24'h000010}};

   int nchk = 0, nbad = 0, cyc = 0, nfr = 0, npulse = 0, cur_bits = 0, viol = 0;
   logic [23:0] cur = '0;
   int f_len [32];
   int f_dat [32];
   int t_beg [32];
   int t_end [32];
   int p_beg [32];
   bit finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge cs_n) begin
      cur_bits = 0; cur = '0;
      if (nfr < 32) begin t_beg[nfr] = cyc; p_beg[nfr] = npulse; end
   end
   always @(posedge sclk) begin
      if (cs_n) viol = viol + 1;
      cur = {cur[22:0], mosi};
      cur_bits = cur_bits + 1;
   end
   always @(posedge cs_n) begin
      if (cur_bits > 0) begin
         if (nfr < 32) begin f_len[nfr] = cur_bits; f_dat[nfr] = int'(cur); t_end[nfr] = cyc; end
         nfr = nfr + 1;
         cur_bits = 0;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse();
      @(negedge clk);
      drdy_n = 1'b0; npulse++;
      repeat (4) @(negedge clk);
      drdy_n = 1'b1;
      repeat (30) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      if (cyc > 150000) begin
         nchk++; nbad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   initial begin
      int base;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 cs_n in reset", cs_n, 1);
      chk("R1 sclk in reset", sclk, 0);
      chk("R1 done in reset", done, 0);
      rst_n = 1'b1;

      // R10: early data-ready edges during configuration
      wait (nfr >= 2);
      repeat (3) pulse();

      wait (nfr >= 8);
      repeat (600) @(negedge clk);
      chk("R6 hold after first run-read", nfr, 8);
      chk("R8 done low while waiting", done, 0);
      pulse();
      repeat (600) @(negedge clk);
      chk("R6 calibration frames sent", nfr, 11);

      for (int k = 0; k < SETTLE - 1; k++) pulse();
      repeat (600) @(negedge clk);
      chk("R7 hold before settle count", nfr, 11);
      chk("R8 done low before final", done, 0);
      pulse();
      repeat (800) @(negedge clk);
      chk("R7 final frames sent", nfr, NFR);
      chk("R8 done after final frame", done, 1);

      // R9: edges after done
      repeat (3) pulse();
      repeat (300) @(negedge clk);
      chk("R9 no frames after done", nfr, NFR);
      chk("R9 done stays high", done, 1);
      chk("R9 cs_n idle", cs_n, 1);

      // frame table walk: R3, R4, R6, R7
      for (int i = 0; i < NFR; i++) begin
         chk($sformatf("R3/R4 frame %0d length", i), f_len[i], int'(EXP[i][31:24]));
         chk($sformatf("R3/R4 frame %0d data", i), f_dat[i], int'(EXP[i][23:0]));
      end
      // R5 idle gaps
      for (int i = 1; i < NFR; i++)
         chk($sformatf("R5 gap before frame %0d", i), (t_beg[i] - t_end[i-1]) >= GAPC, 1);
      // R2 framing
      chk("R2 clock only under chip select", viol, 0);
      // R6 / R10: exactly one counted edge, three early ones ignored
      chk("R10 early edges not counted", p_beg[8], 4);
      chk("R7 settle edges counted", p_beg[11], 4 + SETTLE);

      // reset restart
      base = nfr;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 done cleared by reset", done, 0);
      chk("R1 cs_n high in reset", cs_n, 1);
      rst_n = 1'b1;
      wait (nfr > base);
      @(negedge clk);
      chk("R3 first frame after reset length", f_len[base], 8);
      chk("R3 first frame after reset data", f_dat[base], 32'h11);
      finish_run();
   end
endmodule